// File: doc/BRIEF.md
# Network Controller Command and Status Word Pair

This block is the host-facing control point of a network controller. A host reaches it through a small register window of three word addresses: a status word, a command word and a pointer operand. Through the command word the host hands separate commands to a command unit and a receive unit. Through the status word it reads the state of both units and a set of event flags. A write of ones to an event flag clears it.

Each command field holds its code until the addressed unit signals that it can take a command. The field then clears itself, and the unit receives a one-cycle dispatch pulse carrying the code and the pointer value that was current when the command was written. A host can therefore poll for both command fields reading zero before it issues the next command. An interrupt line reports any pending event unless the host has masked it, and the host can raise a software event by writing the command word. The real unit engines, descriptor fetching and DMA sit outside this block. Ready, state and event inputs stand in for them.

Top module: `nic_ctl_block`

## Requirements
- R1: After reset all event flags and both pending command fields are zero, the interrupt mask (command bit 8) reads 1, the pointer reads 0, irq is low and neither dispatch pulse is active.
- R2: The status word (address 0) holds event flags in bits 15..8, with ev_in[k] setting status bit 8+k: 15 command done, 14 frame received, 13 command unit left active, 12 receiver left ready, 11 management cycle done, 10 software interrupt, 8 flow-control pause. Bit 9 always reads 0. Bits 7:6 mirror cu_state and bits 5:2 mirror ru_state (0 idle, 1 suspended, 2 no resources, 4 ready, plus 8 when no buffer descriptors are left). Bits 1:0 read 0.
- R3: A write to the status word clears each event flag whose data bit is 1 under mask 0xFD00. Data bits that are 0 leave the flags unchanged.
- R4: When an event arrives in the same cycle as a host write that clears that flag, the flag ends set.
- R5: A write to the command word (address 1) latches the command-unit code from bits 7:4 (1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base, 7 dump and reset) and the receive-unit code from bits 2:0 (1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources). The latched codes read back in the same positions until they are accepted.
- R6: A pending code is accepted at the first clock edge at which its unit's ready input is high. At that edge the field clears, and in the following cycle the unit's go output is high with that code on its command output.
- R7: The pointer (address 2) is a full-width register. The dispatch carries the pointer value held when the command was written, and later pointer writes do not alter it.
- R8: Reserved codes (command unit 3 and 8..15, receive unit 3 and 5) are discarded: the field keeps its previous content and nothing is dispatched.
- R9: Command bit 8 is the interrupt mask. While it is 1, irq is low. While it is 0, irq is high exactly when any event flag is set.
- R10: A command write with bit 9 set sets event flag 10, and bit 9 reads back as 0.
- R11: A code of 0 in one field of a command write leaves that unit's pending command untouched. A legal nonzero code replaces a pending one, together with its pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| reg_addr | input | 2 | Word select: 0 status, 1 command, 2 pointer |
| wr_data | input | PTR_W | Host write data |
| rd_data | output | PTR_W | Read data for reg_addr |
| ev_in | input | 8 | Event set pulses for status bits 15..8 |
| cu_state | input | 2 | Command unit state |
| ru_state | input | 4 | Receive unit state |
| cu_ready | input | 1 | Command unit can take a command |
| ru_ready | input | 1 | Receive unit can take a command |
| cu_go | output | 1 | Command unit dispatch pulse |
| cu_go_cmd | output | 4 | Dispatched command unit code |
| cu_go_ptr | output | PTR_W | Pointer sent with command unit code |
| ru_go | output | 1 | Receive unit dispatch pulse |
| ru_go_cmd | output | 3 | Dispatched receive unit code |
| ru_go_ptr | output | PTR_W | Pointer sent with receive unit code |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same flag in the same cycle: a unit event setting a flag and a host write clearing it. The bench drives ev_in for a flag during the exact cycle of a status write with that flag's bit at one. It then expects the flag to read set, and it clears the flag with a second, lone write. A second overlap, a command write landing while the other unit's command is still pending, is judged through the scoreboard of dispatched code and pointer pairs.

// File: rtl/nic_ctl_block.sv
module nic_ctl_block #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] rd_data,
  input  logic [7:0]       ev_in,
  input  logic [1:0]       cu_state,
  input  logic [3:0]       ru_state,
  input  logic             cu_ready,
  input  logic             ru_ready,
  output logic             cu_go,
  output logic [3:0]       cu_go_cmd,
  output logic [PTR_W-1:0] cu_go_ptr,
  output logic             ru_go,
  output logic [2:0]       ru_go_cmd,
  output logic [PTR_W-1:0] ru_go_ptr,
  output logic             irq
);
  localparam logic [7:0] ACK_MASK = 8'hFD;
  localparam int PAD_W = PTR_W - 16;

  logic [7:0]       ev_q;
  logic             irq_off_q;
  logic [3:0]       cu_pend_q;
  logic [2:0]       ru_pend_q;
  logic [PTR_W-1:0] ptr_q, cu_ptr_q, ru_ptr_q;

  function automatic logic cu_legal(input logic [3:0] c);
    return c inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7};
  endfunction

  function automatic logic ru_legal(input logic [2:0] c);
    return c inside {3'd1, 3'd2, 3'd4, 3'd6, 3'd7};
  endfunction

  wire wr_stat = wr_en && (reg_addr == 2'd0);
  wire wr_cmd  = wr_en && (reg_addr == 2'd1);
  wire wr_ptr  = wr_en && (reg_addr == 2'd2);

  wire cu_load = wr_cmd && cu_legal(wr_data[7:4]);
  wire ru_load = wr_cmd && ru_legal(wr_data[2:0]);
  wire cu_take = (cu_pend_q != 4'd0) && cu_ready;
  wire ru_take = (ru_pend_q != 3'd0) && ru_ready;

  wire [7:0] ev_clr = wr_stat ? (wr_data[15:8] & ACK_MASK) : 8'h00;
  wire [7:0] ev_set = (ev_in & ACK_MASK) | {5'b0, wr_cmd & wr_data[9], 2'b0};

  wire [15:0] stat_word = {ev_q, cu_state, ru_state, 2'b00};
  wire [15:0] cmd_word  = {7'b0, irq_off_q, cu_pend_q, 1'b0, ru_pend_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q      <= 8'h00;
      irq_off_q <= 1'b1;
      ptr_q     <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (wr_cmd) irq_off_q <= wr_data[8];
      if (wr_ptr) ptr_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_pend_q <= 4'd0;
      cu_ptr_q  <= '0;
      cu_go     <= 1'b0;
      cu_go_cmd <= 4'd0;
      cu_go_ptr <= '0;
    end else begin
      cu_go     <= cu_take;
      cu_go_cmd <= cu_take ? cu_pend_q : 4'd0;
      if (cu_take) cu_go_ptr <= cu_ptr_q;
      if (cu_load) begin
        cu_pend_q <= wr_data[7:4];
        cu_ptr_q  <= ptr_q;
      end else if (cu_take) begin
        cu_pend_q <= 4'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ru_pend_q <= 3'd0;
      ru_ptr_q  <= '0;
      ru_go     <= 1'b0;
      ru_go_cmd <= 3'd0;
      ru_go_ptr <= '0;
    end else begin
      ru_go     <= ru_take;
      ru_go_cmd <= ru_take ? ru_pend_q : 3'd0;
      if (ru_take) ru_go_ptr <= ru_ptr_q;
      if (ru_load) begin
        ru_pend_q <= wr_data[2:0];
        ru_ptr_q  <= ptr_q;
      end else if (ru_take) begin
        ru_pend_q <= 3'd0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    rd_data = {{PAD_W{1'b0}}, stat_word};
      2'd1:    rd_data = {{PAD_W{1'b0}}, cmd_word};
      2'd2:    rd_data = ptr_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = ~irq_off_q & (|ev_q);
endmodule

// File: rtl/nic_ctl_block_chk.sv
module nic_ctl_block_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  reg_addr,
  input logic [15:4] wd,
  input logic        cu_ready,
  input logic        ru_ready,
  input logic [7:0]  ev_q,
  input logic        irq_off_q,
  input logic [3:0]  cu_pend_q,
  input logic [2:0]  ru_pend_q,
  input logic        cu_go,
  input logic [3:0]  cu_go_cmd,
  input logic        ru_go,
  input logic [2:0]  ru_go_cmd,
  input logic        irq
);
  logic [7:0] clr_c;
  assign clr_c = (wr_en && reg_addr == 2'd0) ? (wd[15:8] & 8'hFD) : 8'h00;

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off_q |-> !irq);

  p_cu_go_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cu_go |-> ($past(cu_ready) && $past(cu_pend_q) != 4'd0 && cu_go_cmd == $past(cu_pend_q)));

  p_ru_go_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ru_go |-> ($past(ru_ready) && $past(ru_pend_q) != 3'd0 && ru_go_cmd == $past(ru_pend_q)));

  p_w1c_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ev_q) & ~$past(clr_c)) & ~ev_q) == 8'h00));

  p_swi_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 2'd1 && wd[9]) |=> ev_q[2]);

  p_bit9_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_q[1]);

  p_cu_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 2'd1 && wd[7:4] == 4'd3 && cu_pend_q == 4'd0) |=> cu_pend_q == 4'd0);
endmodule

bind nic_ctl_block nic_ctl_block_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wd(wr_data[15:4]),
  .cu_ready(cu_ready), .ru_ready(ru_ready), .ev_q(ev_q), .irq_off_q(irq_off_q),
  .cu_pend_q(cu_pend_q), .ru_pend_q(ru_pend_q), .cu_go(cu_go), .cu_go_cmd(cu_go_cmd),
  .ru_go(ru_go), .ru_go_cmd(ru_go_cmd), .irq(irq)
);

// File: tb/nic_ctl_block_tb_top.sv
`timescale 1ns/1ps
module nic_ctl_block_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  ev_in = 8'h0;
  logic [1:0]  cu_state = 2'b01;
  logic [3:0]  ru_state = 4'h4;
  logic        cu_ready = 1'b0, ru_ready = 1'b0;
  wire  [31:0] rd_data, cu_go_ptr, ru_go_ptr;
  wire         cu_go, ru_go, irq;
  wire  [3:0]  cu_go_cmd;
  wire  [2:0]  ru_go_cmd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [35:0] cu_q[$];
  logic [34:0] ru_q[$];

  nic_ctl_block #(.PTR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .ev_in(ev_in), .cu_state(cu_state), .ru_state(ru_state),
    .cu_ready(cu_ready), .ru_ready(ru_ready), .cu_go(cu_go), .cu_go_cmd(cu_go_cmd),
    .cu_go_ptr(cu_go_ptr), .ru_go(ru_go), .ru_go_cmd(ru_go_cmd), .ru_go_ptr(ru_go_ptr),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && cu_go) begin
      if (cu_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected cu dispatch: actual 0x%h expected none", cu_go_cmd);
      end else begin
        logic [35:0] e;
        e = cu_q.pop_front();
        check("R6 cu dispatched code", {28'b0, cu_go_cmd}, {28'b0, e[35:32]});
        check("R7 cu dispatched pointer", cu_go_ptr, e[31:0]);
      end
    end
    if (rst_n && ru_go) begin
      if (ru_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected ru dispatch: actual 0x%h expected none", ru_go_cmd);
      end else begin
        logic [34:0] e;
        e = ru_q.pop_front();
        check("R6 ru dispatched code", {29'b0, ru_go_cmd}, {29'b0, e[34:32]});
        check("R7 ru dispatched pointer", ru_go_ptr, e[31:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 status after reset", v, 32'h0000_0050);
    rd(2'd1, v); check("R1 command after reset", v, 32'h0000_0100);
    rd(2'd2, v); check("R1 pointer after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 no dispatch after reset", {30'b0, cu_go, ru_go}, 32'h0);

    // R2 every event input, bit 9 input ignored, state mirrors
    @(negedge clk); ev_in = 8'hFF;
    @(negedge clk); ev_in = 8'h00;
    cu_state = 2'b10; ru_state = 4'hC;
    rd(2'd0, v); check("R2 status layout", v, 32'h0000_FDB0);

    // R9 mask
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0000); check("R9 irq unmasked", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0000_0100); check("R9 irq masked again", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0000);

    // R3 write-one-to-clear
    wr(2'd0, 32'h0000_5500); rd(2'd0, v); check("R3 partial clear", v, 32'h0000_A8B0);
    wr(2'd0, 32'h0000_0000); rd(2'd0, v); check("R3 zeros keep flags", v, 32'h0000_A8B0);
    wr(2'd0, 32'h0000_FFFF); rd(2'd0, v); check("R3 full clear", v, 32'h0000_00B0);
    check("R9 irq low with no events", {31'b0, irq}, 32'h0);

    // R4 set and clear in the same cycle
    @(negedge clk); ev_in = 8'h80; wr_en = 1'b1; reg_addr = 2'd0; wr_data = 32'h8000;
    @(negedge clk); ev_in = 8'h00; wr_en = 1'b0; wr_data = 32'h0;
    rd(2'd0, v); check("R4 set wins over clear", v, 32'h0000_80B0);
    wr(2'd0, 32'h0000_8000); rd(2'd0, v); check("R4 later clear", v, 32'h0000_00B0);

    // R10 software interrupt
    wr(2'd1, 32'h0000_0200);
    rd(2'd0, v); check("R10 software event set", v, 32'h0000_04B0);
    rd(2'd1, v); check("R10 bit 9 reads zero", v, 32'h0);
    check("R10 irq from software event", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0400);

    // R5 R6 R7 latch, hold, accept
    wr(2'd2, 32'h1000_0000);
    wr(2'd1, 32'h0000_0011);
    rd(2'd1, v); check("R5 pending codes read back", v, 32'h0000_0011);
    wr(2'd2, 32'h2222_0000);
    rd(2'd2, v); check("R7 pointer read back", v, 32'h2222_0000);
    cu_q.push_back({4'd1, 32'h1000_0000});
    ru_q.push_back({3'd1, 32'h1000_0000});
    @(negedge clk); cu_ready = 1'b1;
    idle(2);
    rd(2'd1, v); check("R6 cu field cleared, ru held", v, 32'h0000_0001);
    ru_ready = 1'b1;
    idle(2);
    rd(2'd1, v); check("R6 ru field cleared", v, 32'h0);
    cu_ready = 1'b0; ru_ready = 1'b0;

    // R11 nop keeps pending, legal code replaces
    wr(2'd1, 32'h0000_0060);
    wr(2'd1, 32'h0000_0007);
    rd(2'd1, v); check("R11 nop keeps cu pending", v, 32'h0000_0067);
    wr(2'd1, 32'h0000_0070);
    rd(2'd1, v); check("R11 code replaced", v, 32'h0000_0077);
    cu_q.push_back({4'd7, 32'h2222_0000});
    ru_q.push_back({3'd7, 32'h2222_0000});
    @(negedge clk); cu_ready = 1'b1; ru_ready = 1'b1;
    idle(3);
    rd(2'd1, v); check("R11 both accepted", v, 32'h0);

    // R8 reserved codes with both units ready
    wr(2'd1, 32'h0000_0035); idle(3);
    rd(2'd1, v); check("R8 reserved 3/5 dropped", v, 32'h0);
    wr(2'd1, 32'h0000_00F3); idle(3);
    rd(2'd1, v); check("R8 reserved 15/3 dropped", v, 32'h0);
    wr(2'd2, 32'h0ABC_0000);
    cu_q.push_back({4'd5, 32'h0ABC_0000});
    ru_q.push_back({3'd2, 32'h0ABC_0000});
    wr(2'd1, 32'h0000_0052); idle(3);
    rd(2'd1, v); check("R6 immediate accept", v, 32'h0);
    cu_ready = 1'b0; ru_ready = 1'b0;

    idle(4);
    check("R6 all cu dispatches seen", cu_q.size(), 32'd0);
    check("R6 all ru dispatches seen", ru_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule